// File: doc/BRIEF.md
# Addend Alignment Shifter

This block moves the addend significand of a fused multiply-add into position against the product before the two are summed. It does no arithmetic on exponents. A decoder upstream turns the shift amount into three one-hot select groups, and this block applies them in order. A fine group moves the addend by 0 to 3 bits. A middle group moves it by 0, 4, 8 or 12 bits. A coarse group moves it by a multiple of 16, and that multiple can be negative. The shifted vector is registered together with a sticky bit, which is the OR of every addend bit that fell below the least significant output position.

The output window is `OUT_W` bits wide, 227 by default. With a total shift `s`, the addend's most significant bit lands at output bit `OUT_W-65-s`. So a shift of −64 places it at the top bit. A shift of 0 places it 64 bits below the top. With the default width, any shift of 163 or more pushes every addend bit into sticky.

An underflow flag makes the result zero with all of the addend in sticky. An overflow flag places the addend at the top of the window. A special-operand select turns off every coarse path.

Top module: `addend_align_shifter`

## Requirements
- R1: While reset is held and after it, before any input is taken, `aligned_o` is all zero and `sticky_o` is 0.
- R2: The result is registered. Inputs sampled at a rising clock edge appear on the outputs right after that edge, and the outputs hold their value between edges.
- R3: `fine_sel_i[k]` adds k bits and `mid_sel_i[k]` adds 4k bits to the shift. All selects are one-hot, and an all-zero select group yields a zero result. Addend bit i lands at output bit `OUT_W-65-s-(ADD_W-1-i)`, where s is the total shift.
- R4: `coarse_sel_i[k]` adds 16k bits for k from 0 to 10. It adds 16k−256 bits for k from 12 to 15, which gives −64, −48, −32 and −16.
- R5: `sticky_o` is the OR of the addend bits whose landing position is below bit 0. A coarse select in 0..5 or 12..15 never raises sticky.
- R6: For a total shift of 163 or more, `aligned_o` is zero and `sticky_o` is the OR of the whole addend. A total shift of 162 puts the addend MSB at bit 0.
- R7: Coarse line 11 has no shift. When it is the only coarse line set, or no coarse line is set, the result is zero with sticky 0.
- R8: When `special_i` is 1 and neither flag is set, the coarse paths are off, so the result is zero with sticky 0.
- R9: When `unf_i` is 1, `aligned_o` is zero and `sticky_o` is the OR of the addend. This holds whatever the other inputs are, including `ovf_i`.
- R10: When `ovf_i` is 1 and `unf_i` is 0, the addend fills the top `ADD_W` bits of `aligned_o`, `sticky_o` is 0, and every select is ignored.
- R11: With one-hot selects, `aligned_o` never has more set bits than `ADD_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addend_i | input | ADD_W | Addend significand |
| fine_sel_i | input | FINE_N | One-hot fine shift select (k bits) |
| mid_sel_i | input | MID_N | One-hot middle shift select (4k bits) |
| coarse_sel_i | input | COARSE_N | One-hot coarse shift select (signed multiples of 16) |
| special_i | input | 1 | Special operand; disables all coarse paths |
| unf_i | input | 1 | Shift underflow: whole addend to sticky |
| ovf_i | input | 1 | Shift overflow: addend at top of window |
| aligned_o | output | OUT_W | Registered aligned addend |
| sticky_o | output | 1 | Registered OR of bits shifted below bit 0 |

## Verification
The assertions rely on the upstream decoder to drive each select group with at most one line set. The count bound on `aligned_o` and the no-sticky property for short shifts only hold under that condition, so both are written with the one-hot check in the antecedent. The directed and random stimulus always drives exactly one line per group, or an all-zero group on purpose. Coarse line 11 and the special select are driven only in their own scenarios. The two flags are asserted alone and together, so their order of priority is exercised.

// File: rtl/addend_align_pkg.sv
package addend_align_pkg;

    // Coarse select line that carries no shift.
    localparam int HOLE_CODE   = 11;
    // Magnitude of the largest leftward coarse step.
    localparam int NEG_SPAN    = 64;
    localparam int COARSE_STEP = 16;

    // Signed shift of coarse line k out of n lines: lower lines positive,
    // lines above the hole wrap to negative multiples of the step.
    function automatic int coarse_shift(int k, int n);
        if (k < HOLE_CODE) return k * COARSE_STEP;
        else               return (k - n) * COARSE_STEP;
    endfunction

endpackage

// File: rtl/onehot_rshift.sv
// Lossless one-hot selected right shift: output keeps every input bit.
module onehot_rshift #(
    parameter int IW   = 53,
    parameter int N    = 4,
    parameter int STEP = 1
) (
    input  logic [IW-1:0]            din,
    input  logic [N-1:0]             sel,
    output logic [IW+(N-1)*STEP-1:0] dout
);
    localparam int PAD = (N - 1) * STEP;
    localparam int OW  = IW + PAD;

    logic [OW-1:0] ext;
    assign ext = {din, {PAD{1'b0}}};

    always_comb begin
        dout = '0;
        for (int k = 0; k < N; k++) begin
            if (sel[k]) dout = dout | (ext >> (k * STEP));
        end
    end
endmodule

// File: rtl/coarse_align_stage.sv
// Coarse stage: one fixed-shift path per select line, AND-OR combined.
module coarse_align_stage
    import addend_align_pkg::*;
#(
    parameter int EW    = 68,
    parameter int OUT_W = 227,
    parameter int N     = 16
) (
    input  logic [EW-1:0]    ew_i,
    input  logic [N-1:0]     sel_i,
    output logic [OUT_W-1:0] aligned_o,
    output logic             sticky_o
);
    // Bits of ew_i that land below output bit 0 for a path shift sh.
    function automatic logic [EW-1:0] low_mask(int sh);
        logic [EW-1:0] m;
        for (int j = 0; j < EW; j++) m[j] = (j < sh + EW - OUT_W);
        return m;
    endfunction

    logic [OUT_W-1:0] cand_out [N];
    logic [N-1:0]     cand_st;

    for (genvar k = 0; k < N; k++) begin : g_code
        if (k == HOLE_CODE) begin : g_hole
            assign cand_out[k] = '0;
            assign cand_st[k]  = 1'b0;
        end else begin : g_path
            localparam int            SH   = coarse_shift(k, N) + NEG_SPAN;
            localparam logic [EW-1:0] LOWM = low_mask(SH);
            assign cand_out[k] = OUT_W'({ew_i, {OUT_W{1'b0}}} >> (SH + EW));
            assign cand_st[k]  = |(ew_i & LOWM);
        end
    end

    always_comb begin
        aligned_o = '0;
        sticky_o  = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (sel_i[k]) begin
                aligned_o = aligned_o | cand_out[k];
                sticky_o  = sticky_o | cand_st[k];
            end
        end
    end
endmodule

// File: rtl/addend_align_shifter.sv
module addend_align_shifter #(
    parameter int ADD_W    = 53,
    parameter int OUT_W    = 227,
    parameter int FINE_N   = 4,
    parameter int MID_N    = 4,
    parameter int COARSE_N = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADD_W-1:0]    addend_i,
    input  logic [FINE_N-1:0]   fine_sel_i,
    input  logic [MID_N-1:0]    mid_sel_i,
    input  logic [COARSE_N-1:0] coarse_sel_i,
    input  logic                special_i,
    input  logic                unf_i,
    input  logic                ovf_i,
    output logic [OUT_W-1:0]    aligned_o,
    output logic                sticky_o
);
    localparam int MID_STEP = FINE_N;
    localparam int F_W      = ADD_W + FINE_N - 1;
    localparam int M_W      = F_W + (MID_N - 1) * MID_STEP;

    typedef struct packed {
        logic [OUT_W-1:0] aligned;
        logic             sticky;
    } res_t;

    logic [F_W-1:0]      fine_out;
    logic [M_W-1:0]      mid_out;
    logic [COARSE_N-1:0] coarse_eff;
    logic [OUT_W-1:0]    crs_out;
    logic                crs_st;
    res_t                res_d, res_q;

    onehot_rshift #(.IW(ADD_W), .N(FINE_N), .STEP(1)) u_fine (
        .din  (addend_i),
        .sel  (fine_sel_i),
        .dout (fine_out)
    );

    onehot_rshift #(.IW(F_W), .N(MID_N), .STEP(MID_STEP)) u_mid (
        .din  (fine_out),
        .sel  (mid_sel_i),
        .dout (mid_out)
    );

    assign coarse_eff = special_i ? '0 : coarse_sel_i;

    coarse_align_stage #(.EW(M_W), .OUT_W(OUT_W), .N(COARSE_N)) u_coarse (
        .ew_i      (mid_out),
        .sel_i     (coarse_eff),
        .aligned_o (crs_out),
        .sticky_o  (crs_st)
    );

    always_comb begin
        res_d.aligned = crs_out;
        res_d.sticky  = crs_st;
        if (unf_i) begin
            res_d.aligned = '0;
            res_d.sticky  = |addend_i;
        end else if (ovf_i) begin
            res_d.aligned = {addend_i, {(OUT_W-ADD_W){1'b0}}};
            res_d.sticky  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign aligned_o = res_q.aligned;
    assign sticky_o  = res_q.sticky;
endmodule

// File: rtl/addend_align_shifter_chk.sv
module addend_align_shifter_chk #(
    parameter int ADD_W    = 53,
    parameter int OUT_W    = 227,
    parameter int FINE_N   = 4,
    parameter int MID_N    = 4,
    parameter int COARSE_N = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADD_W-1:0]    addend_i,
    input logic [FINE_N-1:0]   fine_sel_i,
    input logic [MID_N-1:0]    mid_sel_i,
    input logic [COARSE_N-1:0] coarse_sel_i,
    input logic                special_i,
    input logic                unf_i,
    input logic                ovf_i,
    input logic [OUT_W-1:0]    aligned_o,
    input logic                sticky_o
);
    localparam logic [COARSE_N-1:0] HOLE_BIT =
        COARSE_N'(1) << addend_align_pkg::HOLE_CODE;

    // R9
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_i |=> (aligned_o == '0) && (sticky_o == $past(|addend_i)));

    // R10
    ovf_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !unf_i) |=>
            (aligned_o == {$past(addend_i), {(OUT_W-ADD_W){1'b0}}}) && !sticky_o);

    // R8
    special_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (special_i && !unf_i && !ovf_i) |=> (aligned_o == '0) && !sticky_o);

    // R7
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((coarse_sel_i & ~HOLE_BIT) == '0) && !unf_i && !ovf_i)
            |=> (aligned_o == '0) && !sticky_o);

    // R5
    near_no_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|coarse_sel_i[5:0] || |coarse_sel_i[15:12]) && !unf_i && !ovf_i &&
         $onehot0(fine_sel_i) && $onehot0(mid_sel_i) && $onehot0(coarse_sel_i))
            |=> !sticky_o);

    // R11
    ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(fine_sel_i) && $onehot0(mid_sel_i) && $onehot0(coarse_sel_i))
            |=> ($countones(aligned_o) <= ADD_W));
endmodule

bind addend_align_shifter addend_align_shifter_chk #(
    .ADD_W(ADD_W), .OUT_W(OUT_W), .FINE_N(FINE_N), .MID_N(MID_N), .COARSE_N(COARSE_N)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addend_i     (addend_i),
    .fine_sel_i   (fine_sel_i),
    .mid_sel_i    (mid_sel_i),
    .coarse_sel_i (coarse_sel_i),
    .special_i    (special_i),
    .unf_i        (unf_i),
    .ovf_i        (ovf_i),
    .aligned_o    (aligned_o),
    .sticky_o     (sticky_o)
);

// File: tb/addend_align_shifter_bench.sv
module addend_align_shifter_bench;
    localparam int ADD_W = 53;
    localparam int OUT_W = 227;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ADD_W-1:0] addend = '0;
    logic [3:0]       fine = '0;
    logic [3:0]       mid = '0;
    logic [15:0]      coarse = '0;
    logic             special = 1'b0;
    logic             unf = 1'b0;
    logic             ovf = 1'b0;
    logic [OUT_W-1:0] aligned;
    logic             sticky;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    addend_align_shifter u_addend_align_shifter (
        .clk(clk), .rst_n(rst_n), .addend_i(addend), .fine_sel_i(fine),
        .mid_sel_i(mid), .coarse_sel_i(coarse), .special_i(special),
        .unf_i(unf), .ovf_i(ovf), .aligned_o(aligned), .sticky_o(sticky)
    );

    // Reference: place each addend bit directly from the total shift.
    task automatic model(input logic [ADD_W-1:0] a, input int f, input int m,
                         input int c, input logic sp, input logic u, input logic o,
                         output logic [OUT_W-1:0] e, output logic es);
        int s;
        int cs;
        e  = '0;
        es = 1'b0;
        if (u) begin
            es = |a;
        end else if (o) begin
            e = {a, {(OUT_W-ADD_W){1'b0}}};
        end else if (!(sp || c < 0 || c == 11 || f < 0 || m < 0)) begin
            cs = (c < 11) ? 16 * c : 16 * (c - 16);
            s  = f + 4 * m + cs;
            for (int i = 0; i < ADD_W; i++) begin
                int p;
                p = OUT_W - 65 - s - (ADD_W - 1 - i);
                if (a[i]) begin
                    if (p >= 0) e[p] = 1'b1;
                    else        es = 1'b1;
                end
            end
        end
    endtask

    task automatic check(input string req, input logic [OUT_W-1:0] ea, input logic es);
        tests++;
        if (aligned !== ea || sticky !== es) begin
            fails++;
            $display("FAIL %s: actual aligned=%h sticky=%b expected aligned=%h sticky=%b",
                     req, aligned, sticky, ea, es);
        end
    endtask

    // Drive one vector (index -1 means an all-zero group), sample after one edge.
    task automatic run(input string req, input logic [ADD_W-1:0] a, input int f,
                       input int m, input int c, input logic sp, input logic u,
                       input logic o);
        logic [OUT_W-1:0] e;
        logic es;
        @(negedge clk);
        addend  = a;
        fine    = (f < 0) ? 4'b0 : 4'(1 << f);
        mid     = (m < 0) ? 4'b0 : 4'(1 << m);
        coarse  = (c < 0) ? 16'b0 : 16'(1 << c);
        special = sp;
        unf     = u;
        ovf     = o;
        model(a, f, m, c, sp, u, o, e, es);
        @(negedge clk);
        check(req, e, es);
    endtask

    task automatic t_reset;
        #1;
        check("R1 in reset", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check("R1 after release", '0, 1'b0);
    endtask

    task automatic t_latency;
        logic [OUT_W-1:0] e;
        logic es;
        run("R2 first vector", 53'h1F_FFFF_FFFF_FFFF, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        model(53'h1F_FFFF_FFFF_FFFF, 0, 0, 0, 1'b0, 1'b0, 1'b0, e, es);
        @(negedge clk);
        addend = 53'h1;
        #1;
        check("R2 holds before edge", e, es);
        @(negedge clk);
        model(53'h1, 0, 0, 0, 1'b0, 1'b0, 1'b0, e, es);
        check("R2 updates after edge", e, es);
    endtask

    task automatic t_fine_mid;
        for (int f = 0; f < 4; f++)
            run("R3 fine step", 53'h10_0000_0000_0001, f, 0, 0, 1'b0, 1'b0, 1'b0);
        for (int m = 0; m < 4; m++)
            run("R3 mid step", 53'h15_5555_5555_5555, 1, m, 0, 1'b0, 1'b0, 1'b0);
        run("R3 empty fine group", 53'h1F_0000_0000_00FF, -1, 0, 0, 1'b0, 1'b0, 1'b0);
        run("R3 empty mid group", 53'h1F_0000_0000_00FF, 0, -1, 0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_coarse;
        for (int c = 0; c < 11; c++)
            run("R4 R5 positive coarse", 53'h1A_BCDE_F012_3457, 3, 3, c, 1'b0, 1'b0, 1'b0);
        for (int c = 12; c < 16; c++)
            run("R4 negative coarse", 53'h1A_BCDE_F012_3457, 2, 1, c, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_threshold;
        run("R6 shift 162 msb at bit 0", 53'h1F_FFFF_FFFF_FFFF, 2, 0, 10, 1'b0, 1'b0, 1'b0);
        run("R6 shift 163 all sticky", 53'h1F_FFFF_FFFF_FFFF, 3, 0, 10, 1'b0, 1'b0, 1'b0);
        run("R6 shift 175 all sticky", 53'h00_0000_0000_0001, 3, 3, 10, 1'b0, 1'b0, 1'b0);
        run("R5 lsb only lost", 53'h00_0000_0000_0001, 3, 3, 6, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hole_special;
        run("R7 hole line", 53'h1F_FFFF_FFFF_FFFF, 0, 0, 11, 1'b0, 1'b0, 1'b0);
        run("R7 no coarse line", 53'h1F_FFFF_FFFF_FFFF, 0, 0, -1, 1'b0, 1'b0, 1'b0);
        run("R8 special", 53'h1F_FFFF_FFFF_FFFF, 1, 2, 3, 1'b1, 1'b0, 1'b0);
        run("R8 special far shift", 53'h1F_FFFF_FFFF_FFFF, 3, 3, 10, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_flags;
        run("R9 underflow", 53'h00_0000_0100_0000, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        run("R9 underflow zero addend", 53'h0, 2, 1, 10, 1'b0, 1'b1, 1'b0);
        run("R9 underflow over overflow", 53'h12_3456_789A_BCDE, 0, 0, 0, 1'b1, 1'b1, 1'b1);
        run("R10 overflow", 53'h12_3456_789A_BCDE, 3, 3, 10, 1'b0, 1'b0, 1'b1);
        run("R10 overflow ignores special", 53'h1F_FFFF_FFFF_FFFF, -1, -1, -1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [ADD_W-1:0] a;
            int c;
            a = {$urandom(), $urandom()};
            c = $urandom_range(0, 14);
            if (c >= 11) c++;
            run("R3 R4 R5 random", a, $urandom_range(0, 3), $urandom_range(0, 3),
                c, 1'b0, 1'b0, 1'b0);
            tests++;
            if ($countones(aligned) > ADD_W) begin
                fails++;
                $display("FAIL R11: actual ones=%0d expected <= %0d",
                         $countones(aligned), ADD_W);
            end
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_fine_mid();
        t_coarse();
        t_threshold();
        t_hole_special();
        t_flags();
        t_random();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule